// File: doc/BRIEF.md
# Serial Ethernet CRC-32 Generator with Selectable Register Form

This block computes the 32-bit Ethernet frame check value one bit per clock. It can be built in either of two register forms, chosen by a parameter. The first form feeds each data bit in at the top of the register, so it multiplies the message by x^32 while it divides. The second form is a plain polynomial divider with the data bit entering at the bottom. Both forms return the same check value for every frame, including frames shorter than 32 bits.

The multiply-and-divide form starts each frame from an all-ones register. This has the same effect as inverting the first 32 frame bits. The divide-only form cannot use that preset. It starts from zero, inverts the first 32 bits of the stream itself, and then shifts 32 zero bits through to supply the missing x^32 factor. A register value of zero reached during a frame is a normal state and is kept as it is.

Each data bit comes with a valid strobe. The first bit also carries start-of-frame and the last bit carries end-of-frame. Octets are sent least significant bit first. When the frame is complete, the block raises a one-cycle done strobe. In that same cycle it presents the transmit check value and a pass flag, which is used when the frame already carries its check field.

Top module: `crc32_serial_gen`

## Requirements
- R1: The multiply-and-divide form loads all ones on the start-of-frame bit. `crc_out` is the bitwise complement of the bit-reversed register. For the octets of the ASCII text "123456789", each octet sent LSB first, the result is 0xCBF43926.
- R2: The divide-only form produces the same `crc_out` as the multiply-and-divide form for every frame.
- R3: After reset, `done` and `crc_ok` are low. The multiply-and-divide form raises `done` in the cycle after the end-of-frame bit is sampled. The divide-only form raises it 32 cycles later than that.
- R4: `crc_ok` is high with `done` exactly when the frame ends with a correct check field, which leaves the register at 0xC704DD7B (`crc_out` = 0x2144DF1C). The check field is the previous `crc_out`, sent bit 0 first. Otherwise `crc_ok` is low.
- R5: Frames of 1 to 31 bits give the same result in both forms. A one-bit frame carries start-of-frame and end-of-frame on the same bit. In the divide-only form, the inversion then continues into the leading flush bits until 32 bits have been inverted.
- R6: A register that reaches zero is not forced elsewhere. If it is zero and further zero bits follow, it stays zero, and `crc_out` is then 0xFFFFFFFF.
- R7: A start-of-frame bit in the middle of an open frame discards that frame and starts a new one.
- R8: While the divide-only form is flushing, it ignores every input, start-of-frame included. It gives exactly one `done` per frame.
- R9: Cycles with `dvalid` low leave the register unchanged, so idle gaps inside a frame do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Marks the first bit of a frame (qualified by dvalid) |
| dvalid | input | 1 | The data bit on din is valid this cycle |
| din | input | 1 | Serial data bit, octets LSB first |
| eof | input | 1 | Marks the last bit of a frame (qualified by dvalid) |
| crc_out | output | 32 | Check value to transmit, valid while done is high |
| done | output | 1 | One-cycle strobe: frame result ready |
| crc_ok | output | 1 | Frame with its check field appended is intact (with done) |

## Verification
Start-of-frame and end-of-frame can fall on the same bit. The preset, or the start of the inversion window, and the completion of the frame then happen in the same clock cycle. Every pattern of 1 to 8 bits is sent through both forms side by side, the one-bit frames included. Each result is judged against a reflected shift-right CRC model written in the bench, on value, on the cycle in which `done` rises and on the pass flag.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;
    localparam int CNT_W = $clog2(CRC_W) + 1;
    localparam int FLW_W = $clog2(CRC_W);

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic { ARCH_SMD, ARCH_DIV } crc_arch_e;

    typedef enum logic [1:0] { DV_IDLE, DV_DATA, DV_FLUSH } dv_state_e;

    typedef struct packed {
        logic sof;
        logic vld;
        logic dat;
        logic eof;
    } sbit_t;

    // bit enters at the top: multiply by x^32 and divide in one step
    function automatic crc_t smd_step(input crc_t r, input logic d);
        logic fb;
        fb = r[CRC_W-1] ^ d;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // bit enters at the bottom: plain polynomial division
    function automatic crc_t div_step(input crc_t r, input logic d);
        return {r[CRC_W-2:0], d} ^ (r[CRC_W-1] ? CRC_POLY : '0);
    endfunction

    function automatic crc_t bit_rev(input crc_t r);
        crc_t o;
        for (int i = 0; i < CRC_W; i++) o[i] = r[CRC_W-1-i];
        return o;
    endfunction

endpackage

// File: rtl/crc32_smd_core.sv
module crc32_smd_core
    import crc32_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sbit_t in_b,
    output crc_t  r_q,
    output logic  fin_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q   <= '1;
            fin_q <= 1'b0;
        end else begin
            fin_q <= in_b.vld & in_b.eof;
            if (in_b.vld)
                r_q <= smd_step(in_b.sof ? '1 : r_q, in_b.dat);
        end
    end

    // R3
    smd_done_chk: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> $past(in_b.vld && in_b.eof));

    // R6
    smd_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q == '0 && in_b.vld && !in_b.sof && !in_b.dat) |=> (r_q == '0));

    // R9
    smd_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_b.vld |=> $stable(r_q));

endmodule

// File: rtl/crc32_div_core.sv
module crc32_div_core
    import crc32_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sbit_t in_b,
    output crc_t  r_q,
    output logic  fin_q
);

    dv_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [FLW_W-1:0] fcnt_q;
    logic             inv;
    logic             take;

    assign inv  = (cnt_q < CNT_W'(CRC_W));
    assign take = in_b.vld & (in_b.sof | (st_q == DV_DATA));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= DV_IDLE;
            r_q    <= '0;
            cnt_q  <= '0;
            fcnt_q <= '0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (st_q == DV_FLUSH) begin
                r_q    <= div_step(r_q, inv);
                cnt_q  <= inv ? cnt_q + 1'b1 : cnt_q;
                fcnt_q <= fcnt_q + 1'b1;
                if (fcnt_q == FLW_W'(CRC_W - 1)) begin
                    st_q  <= DV_IDLE;
                    fin_q <= 1'b1;
                end
            end else if (take) begin
                if (in_b.sof) begin
                    r_q   <= div_step('0, ~in_b.dat);
                    cnt_q <= CNT_W'(1);
                end else begin
                    r_q   <= div_step(r_q, in_b.dat ^ inv);
                    cnt_q <= inv ? cnt_q + 1'b1 : cnt_q;
                end
                fcnt_q <= '0;
                st_q   <= in_b.eof ? DV_FLUSH : DV_DATA;
            end
        end
    end

    // R3
    div_done_chk: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> $past(st_q == DV_FLUSH));

    // R8
    div_flush_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == DV_FLUSH && fcnt_q != FLW_W'(CRC_W - 1)) |=> (st_q == DV_FLUSH));

    // R8
    div_single_done_chk: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q);

    // R2
    div_start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != DV_FLUSH && in_b.vld && in_b.sof) |=> (r_q[CRC_W-1:1] == '0));

    // R6
    div_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q == '0 && st_q == DV_DATA && in_b.vld && !in_b.sof && !in_b.dat
         && cnt_q == CNT_W'(CRC_W)) |=> (r_q == '0));

endmodule

// File: rtl/crc32_fcs_fmt.sv
module crc32_fcs_fmt
    import crc32_pkg::*;
(
    input  crc_t r_in,
    input  logic fin,
    output crc_t crc_out,
    output logic crc_ok
);

    assign crc_out = ~bit_rev(r_in);
    assign crc_ok  = fin & (r_in == CRC_RESIDUE);

endmodule

// File: rtl/crc32_serial_gen.sv
module crc32_serial_gen
    import crc32_pkg::*;
#(
    parameter crc_arch_e ARCH = ARCH_SMD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sof,
    input  logic        dvalid,
    input  logic        din,
    input  logic        eof,
    output logic [31:0] crc_out,
    output logic        done,
    output logic        crc_ok
);

    sbit_t in_b;
    crc_t  r_w;
    logic  fin_w;

    assign in_b = '{sof: sof, vld: dvalid, dat: din, eof: eof};

    generate
        if (ARCH == ARCH_SMD) begin : g_smd
            crc32_smd_core u_core (
                .clk   (clk),
                .rst   (rst),
                .in_b  (in_b),
                .r_q   (r_w),
                .fin_q (fin_w)
            );
        end else begin : g_div
            crc32_div_core u_core (
                .clk   (clk),
                .rst   (rst),
                .in_b  (in_b),
                .r_q   (r_w),
                .fin_q (fin_w)
            );
        end
    endgenerate

    crc32_fcs_fmt u_fmt (
        .r_in    (r_w),
        .fin     (fin_w),
        .crc_out (crc_out),
        .crc_ok  (crc_ok)
    );

    assign done = fin_w;

    // R4
    ok_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        crc_ok |-> (done && crc_out == 32'h2144_DF1C));

endmodule

// File: tb/sim_crc32_serial_gen.sv
`timescale 1ns/1ps
module sim_crc32_serial_gen;
    import crc32_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sof = 1'b0, dvalid = 1'b0, din = 1'b0, eof = 1'b0;
    logic [31:0] c0, c1;
    logic d0, d1, k0, k1;

    int vectors = 0;
    int miscmp  = 0;
    int cyc     = 0;

    logic fbits [0:1023];

    logic        s0_seen = 1'b0, s1_seen = 1'b0;
    logic [31:0] s0_crc, s1_crc;
    logic        s0_ok, s1_ok;
    int          s0_cyc, s1_cyc;

    always #2 clk = ~clk;

    always @(posedge clk) cyc++;

    crc32_serial_gen #(.ARCH(ARCH_SMD)) u0 (
        .clk(clk), .rst(rst), .sof(sof), .dvalid(dvalid), .din(din), .eof(eof),
        .crc_out(c0), .done(d0), .crc_ok(k0));

    crc32_serial_gen #(.ARCH(ARCH_DIV)) u1 (
        .clk(clk), .rst(rst), .sof(sof), .dvalid(dvalid), .din(din), .eof(eof),
        .crc_out(c1), .done(d1), .crc_ok(k1));

    always @(negedge clk) begin
        if (d0) begin s0_seen = 1'b1; s0_crc = c0; s0_ok = k0; s0_cyc = cyc; end
        if (d1) begin s1_seen = 1'b1; s1_crc = c1; s1_ok = k1; s1_cyc = cyc; end
    end

    task automatic chk(input bit good, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!good) begin
            miscmp++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    // reflected shift-right reference, raw state without final complement
    function automatic logic [31:0] ref_state(input int n);
        logic [31:0] s;
        s = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            if (s[0] ^ fbits[i]) s = (s >> 1) ^ 32'hEDB8_8320;
            else                 s = s >> 1;
        end
        return s;
    endfunction

    function automatic logic [31:0] ref_crc(input int n);
        return ~ref_state(n);
    endfunction

    task automatic run_frame(input int n, input bit gaps, input int junk,
                             input bit garbage, input string rq,
                             output logic [31:0] got);
        int          eof_c;
        logic [31:0] expv;
        logic        exp_ok;
        int          w;
        expv   = ref_crc(n);
        exp_ok = (expv == 32'h2144_DF1C);
        eof_c  = 0;
        s0_seen = 1'b0;
        s1_seen = 1'b0;
        for (int j = 0; j < junk; j++) begin
            @(negedge clk);
            sof = (j == 0); dvalid = 1'b1; din = ($urandom_range(0, 1) == 1); eof = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                sof = 1'b0; dvalid = 1'b0; din = ($urandom_range(0, 1) == 1); eof = 1'b0;
            end
            @(negedge clk);
            sof = (i == 0); dvalid = 1'b1; din = fbits[i]; eof = (i == n - 1);
            if (i == n - 1) eof_c = cyc + 1;
        end
        @(negedge clk);
        sof = 1'b0; dvalid = 1'b0; eof = 1'b0;
        if (garbage) begin
            for (int g = 0; g < 30; g++) begin
                @(negedge clk);
                sof    = ($urandom_range(0, 1) == 1);
                dvalid = ($urandom_range(0, 1) == 1);
                din    = ($urandom_range(0, 1) == 1);
                eof    = 1'b0;
            end
            @(negedge clk);
            sof = 1'b0; dvalid = 1'b0;
        end
        w = 0;
        while (!s1_seen && w < 100) begin
            @(posedge clk);
            w++;
        end
        chk(s0_seen && s1_seen, "R3", "done seen", {30'd0, s0_seen, s1_seen}, 32'd3);
        chk(s0_crc == expv, rq, "smd crc", s0_crc, expv);
        // R2: divide-only form agrees with the reference
        chk(s1_crc == expv, "R2", "div crc", s1_crc, expv);
        // R3: done timing for both forms
        chk(s0_cyc == eof_c, "R3", "smd done cycle", s0_cyc, eof_c);
        chk(s1_cyc == eof_c + 32, "R3", "div done cycle", s1_cyc, eof_c + 32);
        // R4: pass flag matches the reference residue test
        chk(s0_ok == exp_ok && s1_ok == exp_ok, "R4", "crc_ok",
            {30'd0, s0_ok, s1_ok}, {30'd0, exp_ok, exp_ok});
        got = s0_crc;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] st;
        int          n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3: reset state
        chk(!d0 && !d1 && !k0 && !k1, "R3", "reset outputs",
            {28'd0, d0, d1, k0, k1}, 32'd0);

        // R1: check text "123456789"
        for (int k = 0; k < 9; k++)
            for (int j = 0; j < 8; j++) fbits[8*k+j] = 1'((8'h31 + k) >> j);
        run_frame(72, 1'b0, 0, 1'b0, "R1", got);
        chk(got == 32'hCBF4_3926, "R1", "check text", got, 32'hCBF4_3926);

        // R5: every frame of 1 to 8 bits, sof and eof together at n=1
        for (int len = 1; len <= 8; len++)
            for (int p = 0; p < (1 << len); p++) begin
                for (int i = 0; i < len; i++) fbits[i] = 1'(p >> i);
                run_frame(len, 1'b0, 0, 1'b0, "R5", got);
            end

        // R5: around the 32-bit inversion boundary
        for (int len = 30; len <= 34; len++)
            for (int r = 0; r < 4; r++) begin
                for (int i = 0; i < len; i++) fbits[i] = ($urandom_range(0, 1) == 1);
                run_frame(len, 1'b0, 0, 1'b0, "R5", got);
            end

        // R9: longer frames with idle gaps
        for (int r = 0; r < 20; r++) begin
            n = $urandom_range(40, 300);
            for (int i = 0; i < n; i++) fbits[i] = ($urandom_range(0, 1) == 1);
            run_frame(n, 1'b1, 0, 1'b0, "R9", got);
        end

        // R4: frames with their own check field appended, then corrupted
        for (int r = 0; r < 10; r++) begin
            n = $urandom_range(8, 200);
            for (int i = 0; i < n; i++) fbits[i] = ($urandom_range(0, 1) == 1);
            st = ref_crc(n);
            for (int k = 0; k < 32; k++) fbits[n+k] = st[k];
            run_frame(n + 32, 1'b0, 0, 1'b0, "R4", got);
            chk(got == 32'h2144_DF1C, "R4", "good frame value", got, 32'h2144_DF1C);
            fbits[$urandom_range(0, n + 31)] ^= 1'b1;
            run_frame(n + 32, r[0], 0, 1'b0, "R4", got);
        end

        // R7: restart by a second start-of-frame inside an open frame
        for (int r = 0; r < 6; r++) begin
            n = $urandom_range(5, 90);
            for (int i = 0; i < n; i++) fbits[i] = ($urandom_range(0, 1) == 1);
            run_frame(n, 1'b0, $urandom_range(1, 40), 1'b0, "R7", got);
        end

        // R8: random activity while the divide-only form flushes
        for (int r = 0; r < 6; r++) begin
            n = $urandom_range(1, 60);
            for (int i = 0; i < n; i++) fbits[i] = ($urandom_range(0, 1) == 1);
            run_frame(n, 1'b0, 0, 1'b1, "R8", got);
        end

        // R6: steer the register to zero, then feed zeros
        for (int i = 0; i < 8; i++) fbits[i] = ($urandom_range(0, 1) == 1);
        for (int k = 8; k < 40; k++) begin
            st = ref_state(k);
            fbits[k] = st[0];
        end
        for (int k = 40; k < 60; k++) fbits[k] = 1'b0;
        run_frame(60, 1'b0, 0, 1'b0, "R6", got);
        chk(got == 32'hFFFF_FFFF, "R6", "zero state kept", got, 32'hFFFF_FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule